// File: doc/BRIEF.md
# Parallel EEPROM Byte-Write Sequencer

This block is the control path between an SRAM-style parallel host bus and a nonvolatile byte array, modelled here as a register memory. The host reads it like a static RAM. A write strobe qualified by chip select hands the block an address and a data byte. From then on the block runs the byte update on its own, and the host bus is free for other traffic. The update first erases the target location and then programs it, and it is timed by an internal counter. The write time is selectable between a short and a long total duration, each given as a number of clock cycles.

Software can see completion in two ways. The first is an open-drain ready/busy indication: `rb_sink` is the pull-down enable for the pad, and a high value means the shared line is pulled low. The second is data polling: while the update runs, any read returns the complement of the top bit of the byte being written, and once the update is done a read returns the stored data. Write protection has three parts. A filter rejects write strobes shorter than a minimum number of cycles, an inhibit input blocks writes, and a supply-good input blocks writes when it is low.

The controller has four named states:
- ST_IDLE: ready, serving reads.
- ST_STROBE: a write strobe is low and its width is being counted.
- ST_ERASE: the first half of the update.
- ST_PROG: the second half of the update.

Its transitions are named as follows:
- strobe_fall: ST_IDLE→ST_STROBE. The address is captured here.
- launch: ST_STROBE→ST_ERASE, on a qualified, unprotected release of the strobe. The data is captured here.
- reject: ST_STROBE→ST_IDLE, on any other release.
- half_done: ST_ERASE→ST_PROG.
- write_done: ST_PROG→ST_IDLE.

Top module: `eeprom_wr_seq`

## Requirements
- R1: When bus_cs_n=0 and bus_oe_n=0 and no update is running, bus_doe=1 and bus_dout equals the byte stored at bus_addr. In every other case with bus_oe_n=1 or bus_cs_n=1, bus_doe=0.
- R2: A write strobe is bus_cs_n=0, bus_we_n=0 and bus_oe_n=1. The address is captured in the first clock the strobe is seen low. Later changes of bus_addr during the strobe do not matter.
- R3: The update starts in the cycle after the clock that first samples the strobe released. It lasts 2*(SHORT_CYC/2) cycles when long_mode=0 at release and 2*(LONG_CYC/2) cycles when long_mode=1 at release.
- R4: rb_sink is 1 exactly while the update runs and is 0 after reset.
- R5: The update erases the location to all ones and then programs the captured byte. Afterwards, a read of that address returns the captured byte, whatever the location held before.
- R6: A read during the update drives bus_doe=1 with bus_dout[7] equal to the inverse of bit 7 of the byte being written and bus_dout[6:0]=0. After the update the true stored byte is returned.
- R7: A strobe sampled low for fewer than FILT clocks starts no update and leaves memory unchanged.
- R8: A strobe released while wr_inhibit=1 or supply_ok=0 starts no update and leaves memory unchanged.
- R9: A strobe that arrives during an update is ignored. The captured address and data stay unchanged until the update completes.
- R10: The data byte is taken from bus_din in the clock that samples the strobe released. Earlier values on bus_din are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_addr | input | AW | Byte address |
| bus_din | input | 8 | Write data from host |
| bus_dout | output | 8 | Read data to host |
| bus_doe | output | 1 | Read data drive enable |
| long_mode | input | 1 | 1 selects the long write time |
| wr_inhibit | input | 1 | 1 blocks writes |
| supply_ok | input | 1 | 0 blocks writes |
| rb_sink | output | 1 | Open-drain pull-down enable for ready/busy (1 = busy) |

## Verification
A vector table drives writes that mix both write-time modes and both polarities of the top data bit, and it overwrites a location that already holds data. This separates the correct erase-then-program result and the correct poll bit from a design that merges bits or keeps stale values. Strobe widths just below and at the filter limit separate accepted pulses from rejected ones. Directed patterns move the address and data during a strobe, which shows which edge captures each of them. Other directed patterns assert inhibit, drop the supply and fire a second strobe during an update, and readback after each one shows that nothing was written.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_ERASE  = 2'd2,
        ST_PROG   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/strobe_filter.sv
// Counts consecutive sampled-low clocks of the write strobe, saturating at FILT.
module strobe_filter #(
    parameter int FILT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    output logic qual
);
    localparam int FW = $clog2(FILT + 1);
    logic [FW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!act)
            cnt <= '0;
        else if (cnt != FW'(FILT))
            cnt <= cnt + 1'b1;
    end

    assign qual = (cnt == FW'(FILT));
endmodule

// File: rtl/phase_timer.sv
// Runs while enabled; pulses done at the last cycle of each half phase.
module phase_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] half_len,
    output logic          done
);
    logic [TW-1:0] cnt;

    assign done = run && (cnt == half_len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || done)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/byte_array.sv
// Register model of the nonvolatile cell array: one write port, one combinational read port.
module byte_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq
    import eeprom_seq_pkg::*;
#(
    parameter int AW        = 10,
    parameter int SHORT_CYC = 10000,
    parameter int LONG_CYC  = 50000,
    parameter int FILT      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs_n,
    input  logic          bus_oe_n,
    input  logic          bus_we_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_din,
    output logic [7:0]    bus_dout,
    output logic          bus_doe,
    input  logic          long_mode,
    input  logic          wr_inhibit,
    input  logic          supply_ok,
    output logic          rb_sink
);
    localparam int DW         = 8;
    localparam int SHORT_HALF = SHORT_CYC / 2;
    localparam int LONG_HALF  = LONG_CYC / 2;
    localparam int TW         = $clog2(LONG_HALF + 1);

    seq_state_t    state, nxt;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          long_q;
    logic          strobe_act, strobe_qual, launch, phase_done, busy, rd_req;
    logic          arr_wr;
    logic [DW-1:0] arr_wdata, arr_rdata;
    logic [TW-1:0] half_len;

    assign strobe_act = !bus_cs_n && !bus_we_n && bus_oe_n;
    assign launch     = (state == ST_STROBE) && !strobe_act && strobe_qual
                        && !wr_inhibit && supply_ok;
    assign half_len   = long_q ? TW'(LONG_HALF) : TW'(SHORT_HALF);

    strobe_filter #(.FILT(FILT)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (strobe_act),
        .qual  (strobe_qual)
    );

    phase_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_len (half_len),
        .done     (phase_done)
    );

    byte_array #(.AW(AW), .DW(DW)) u_arr (
        .clk     (clk),
        .wr_en   (arr_wr),
        .wr_addr (addr_q),
        .wr_data (arr_wdata),
        .rd_addr (bus_addr),
        .rd_data (arr_rdata)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (strobe_act) nxt = ST_STROBE;
            ST_STROBE: if (!strobe_act) nxt = launch ? ST_ERASE : ST_IDLE;
            ST_ERASE:  if (phase_done) nxt = ST_PROG;
            ST_PROG:   if (phase_done) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            data_q <= '0;
            long_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && strobe_act)
                addr_q <= bus_addr;
            if (launch) begin
                data_q <= bus_din;
                long_q <= long_mode;
            end
        end
    end

    // outputs and array write control
    always_comb begin
        busy      = (state == ST_ERASE) || (state == ST_PROG);
        rd_req    = !bus_cs_n && !bus_oe_n;
        arr_wr    = launch || ((state == ST_PROG) && phase_done);
        arr_wdata = launch ? '1 : data_q;
        rb_sink   = busy;
        bus_doe   = rd_req;
        if (!rd_req)
            bus_dout = '0;
        else if (busy)
            bus_dout = {~data_q[DW-1], {(DW-1){1'b0}}};
        else
            bus_dout = arr_rdata;
    end
endmodule

// File: rtl/eeprom_wr_seq_chk.sv
module eeprom_wr_seq_chk #(
    parameter int AW       = 10,
    parameter int LONG_CYC = 50000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_oe_n,
    input logic          bus_doe,
    input logic [7:0]    bus_dout,
    input logic          rb_sink,
    input logic          wr_inhibit,
    input logic          supply_ok,
    input logic [AW-1:0] addr_q,
    input logic [7:0]    data_q
);
    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_run <= 0;
        else if (rb_sink)
            busy_run <= busy_run + 1;
        else
            busy_run <= 0;
    end

    p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_n |-> !bus_doe);

    p_busy_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= LONG_CYC);

    p_poll_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_sink && bus_doe) |-> (bus_dout[7] == ~data_q[7] && bus_dout[6:0] == 7'd0));

    p_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rb_sink && (wr_inhibit || !supply_ok)) |=> !rb_sink);

    p_hold_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_sink && $past(rb_sink)) |-> ($stable(addr_q) && $stable(data_q)));
endmodule

bind eeprom_wr_seq eeprom_wr_seq_chk #(.AW(AW), .LONG_CYC(LONG_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_oe_n   (bus_oe_n),
    .bus_doe    (bus_doe),
    .bus_dout   (bus_dout),
    .rb_sink    (rb_sink),
    .wr_inhibit (wr_inhibit),
    .supply_ok  (supply_ok),
    .addr_q     (addr_q),
    .data_q     (data_q)
);

// File: tb/eeprom_wr_seq_tb.sv
module eeprom_wr_seq_tb;
    localparam int AW = 6, SC = 20, LC = 60, FILT = 3;
    localparam int NS = 2 * (SC / 2), NL = 2 * (LC / 2);
    // vector: addr[19:14] data[13:6] long[5] width[4:1] accept[0]
    localparam int NV = 7;
    localparam logic [19:0] VEC [NV] = '{
        {6'h05, 8'hA5, 1'b0, 4'd3, 1'b1},
        {6'h05, 8'h3C, 1'b1, 4'd5, 1'b1},
        {6'h12, 8'h00, 1'b0, 4'd4, 1'b1},
        {6'h12, 8'h80, 1'b0, 4'd3, 1'b1},
        {6'h05, 8'h7E, 1'b1, 4'd2, 1'b0},
        {6'h3F, 8'h81, 1'b1, 4'd6, 1'b1},
        {6'h12, 8'h55, 1'b0, 4'd1, 1'b0}
    };

    logic clk = 0, rst_n = 0;
    logic bus_cs_n = 1, bus_oe_n = 1, bus_we_n = 1;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0] bus_din = '0, bus_dout;
    logic bus_doe, long_mode = 0, wr_inhibit = 0, supply_ok = 1, rb_sink;
    int checks = 0, errors = 0;
    logic [7:0] model [64];

    always #10 clk = ~clk;

    eeprom_wr_seq #(.AW(AW), .SHORT_CYC(SC), .LONG_CYC(LC), .FILT(FILT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .long_mode(long_mode),
        .wr_inhibit(wr_inhibit), .supply_ok(supply_ok), .rb_sink(rb_sink)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // strobe: address a then a_late, data d_early then d at release; ends at first negedge after release
    task automatic do_write(input logic [AW-1:0] a, input logic [AW-1:0] a_late,
                            input logic [7:0] d_early, input logic [7:0] d,
                            input logic lm, input int w);
        @(negedge clk);
        bus_cs_n = 0; bus_oe_n = 1; bus_we_n = 0; bus_addr = a; bus_din = d_early; long_mode = lm;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            bus_addr = a_late;
        end
        bus_we_n = 1; bus_din = d;
        @(negedge clk);
        bus_cs_n = 1;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] v, output logic oe);
        @(negedge clk);
        bus_cs_n = 0; bus_oe_n = 0; bus_addr = a;
        #1 v = bus_dout; oe = bus_doe;
        @(negedge clk);
        bus_cs_n = 1; bus_oe_n = 1;
    endtask

    task automatic wait_idle();
        while (rb_sink) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic oe;
        repeat (3) @(negedge clk);
        // reset state
        check("R4 reset rb_sink", rb_sink, 0);
        check("R1 reset doe", bus_doe, 0);
        rst_n = 1;

        for (int k = 0; k < NV; k++) begin
            logic [AW-1:0] a = VEC[k][19:14];
            logic [7:0] d = VEC[k][13:6];
            logic lm = VEC[k][5];
            int w = int'(VEC[k][4:1]);
            logic ok = VEC[k][0];
            int n = lm ? NL : NS;
            do_write(a, a, ~d, d, lm, w);
            if (ok) begin
                check("R4 busy after launch", rb_sink, 1);
                bus_cs_n = 0; bus_oe_n = 0; bus_addr = a;
                #1;
                check("R6 poll byte", {bus_doe, bus_dout}, {1'b1, ~d[7], 7'd0});
                @(negedge clk);
                bus_cs_n = 1; bus_oe_n = 1;
                repeat (n - 2) @(negedge clk);
                check("R3 busy at last cycle", rb_sink, 1);
                @(negedge clk);
                check("R3 idle after duration", rb_sink, 0);
                model[a] = d;
                do_read(a, v, oe);
                check("R5 R1 readback", {oe, v}, {1'b1, d});
            end else begin
                check("R7 short strobe no busy", rb_sink, 0);
                do_read(a, v, oe);
                check("R7 memory unchanged", v, model[a]);
            end
        end

        // R1: no drive with cs high
        @(negedge clk);
        bus_cs_n = 1; bus_oe_n = 0;
        #1 check("R1 no drive cs high", bus_doe, 0);
        bus_oe_n = 1;

        // R8: inhibit and supply
        wr_inhibit = 1;
        do_write(6'h05, 6'h05, 8'h01, 8'h01, 0, 4);
        check("R8 inhibit no busy", rb_sink, 0);
        wr_inhibit = 0; supply_ok = 0;
        do_write(6'h05, 6'h05, 8'h02, 8'h02, 0, 4);
        check("R8 supply low no busy", rb_sink, 0);
        supply_ok = 1;
        do_read(6'h05, v, oe);
        check("R8 memory unchanged", v, model[6'h05]);

        // R9: strobe during busy ignored
        do_write(6'h07, 6'h07, 8'h11, 8'h11, 0, 3);
        do_write(6'h12, 6'h12, 8'h22, 8'h22, 0, 4);
        check("R9 still busy", rb_sink, 1);
        wait_idle();
        do_read(6'h07, v, oe);
        check("R9 first write intact", v, 8'h11);
        do_read(6'h12, v, oe);
        check("R9 second write dropped", v, model[6'h12]);

        // R2 / R10: address from fall, data from release
        do_write(6'h20, 6'h21, 8'hC3, 8'h5A, 0, 4);
        wait_idle();
        do_read(6'h20, v, oe);
        check("R2 R10 captured at edges", v, 8'h5A);
        do_write(6'h21, 6'h21, 8'h0F, 8'h0F, 0, 3);
        wait_idle();
        do_read(6'h21, v, oe);
        check("R7 width equal to filter accepted", v, 8'h0F);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule